// File: doc/BRIEF.md
# Deep-Sleep Wakeup Sequencer

This block stays awake while most of the processor core has no power. It watches a vector of interrupt request lines and tells the power management unit when the core may be powered down. When an interrupt arrives, it brings the core back up. It has no registers and no programming interface, and it acts only on hardware signals. It arms only when the deep-sleep control input is set. It never grants power-down while a debugger is attached.

The core requests deep sleep and then signals that it is sleeping. The block then grants power-down. An interrupt seen in that state opens a restore window of a fixed number of cycles. During that window the block asks for state restore. After the window it reports that the core is ready. It also reports every interrupt line that was seen since the wakeup began, so that none is lost.

The length of the window is set by parameter and depends on the power-down level. At the deeper level, which is sampled when power-down is granted, the window is longer. The interrupt lines pass through a configurable synchronizer before the sequencer uses them.

Top module: `wake_seq_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, pwr_down_ok_o, restore_req_o and core_ready_o are 0 and wake_src_o is all zeros.
- R2: pwr_down_ok_o goes high only in the cycle after a clock edge at which deep_sleep_i=1, core_sleeping_i=1 and dbg_attached_i=0, with the block armed. The block becomes armed one edge after deep_sleep_i=1 with no debugger attached.
- R3: If deep_sleep_i drops or dbg_attached_i rises while the block is armed, it returns to idle without granting power-down. A later rise of core_sleeping_i, with deep_sleep_i still low, does not grant power-down.
- R4: In every cycle after a clock edge at which dbg_attached_i=1, pwr_down_ok_o is 0. A debugger attached while the core is powered down starts the restore window.
- R5: An irq_i line seen high while power-down is granted starts the restore window. The line is seen SYNC_STAGES edges after it is sampled. restore_req_o then stays high for exactly DLY_SLEEP cycles when pd_level_i was 0 at the edge that granted power-down.
- R6: When pd_level_i was 1 at the edge that granted power-down, restore_req_o stays high for exactly DLY_DEEP cycles. DLY_DEEP must be greater than DLY_SLEEP.
- R7: After the restore window, core_ready_o is 1 and stays 1 while core_sleeping_i=1. It drops in the cycle after core_sleeping_i is seen low, and the block returns to idle.
- R8: wake_src_o is the bitwise OR of every synchronized irq_i line seen while power-down is granted, during the restore window and while ready. It shows this value only while core_ready_o=1 and is zero otherwise, so an interrupt raised during the restore window is not lost.
- R9: irq_i has no effect while the block is idle or armed: restore_req_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| deep_sleep_i | input | 1 | Deep-sleep control bit from the core |
| core_sleeping_i | input | 1 | Core has entered its sleep state |
| dbg_attached_i | input | 1 | A debugger is connected |
| pd_level_i | input | 1 | 1 selects the deeper power-down level |
| irq_i | input | N_IRQ | Interrupt request lines |
| pwr_down_ok_o | output | 1 | Power management may remove core power |
| restore_req_o | output | 1 | Core state restore in progress |
| core_ready_o | output | 1 | Core restored and ready to take the interrupt |
| wake_src_o | output | N_IRQ | Lines latched since the wakeup started |

## Verification
The sequencer is driven through full sleep and wake cycles at both power-down levels. The measured restore windows are what separate the two delay settings. In one cycle a second interrupt arrives during the restore window, and the reported source vector shows whether that late line was kept or dropped. Aborts from the armed state, both by clearing deep sleep and by attaching a debugger, show whether power-down can be granted wrongly. A debugger attached during power-down, and interrupts raised while idle or armed, show which events may and may not wake the core.

// File: rtl/wake_pkg.sv
package wake_pkg;
   typedef enum logic [2:0] {
      WS_IDLE    = 3'd0,
      WS_ARMED   = 3'd1,
      WS_PDOWN   = 3'd2,
      WS_RESTORE = 3'd3,
      WS_READY   = 3'd4
   } wake_state_e;
endpackage

// File: rtl/wake_irq_sync.sv
module wake_irq_sync #(
   parameter int N      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] irq_i,
   output logic [N-1:0] irq_o
);
   initial begin : param_chk
      assert (STAGES >= 0 && STAGES <= 4) else $error("STAGES out of range");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign irq_o = irq_i;
      end else begin : g_sync
         logic [N-1:0] chain [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) chain[i] <= '0;
            end else begin
               chain[0] <= irq_i;
               for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign irq_o = chain[STAGES-1];

         if (STAGES >= 2) begin : g_chk
            // R5
            sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
               irq_o == $past(chain[STAGES-2]));
         end
      end
   endgenerate
endmodule

// File: rtl/wake_delay_cnt.sv
module wake_delay_cnt #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   input  logic          dec_i,
   output logic          done_o
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (load_i)                 cnt_q <= load_val_i;
      else if (dec_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);

   // R5
   cnt_hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q == '0) |=> cnt_q == '0);
   // R6
   cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/wake_seq_ctrl.sv
module wake_seq_ctrl
   import wake_pkg::*;
#(
   parameter int N_IRQ       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int DLY_SLEEP   = 4,
   parameter int DLY_DEEP    = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             deep_sleep_i,
   input  logic             core_sleeping_i,
   input  logic             dbg_attached_i,
   input  logic             pd_level_i,
   input  logic [N_IRQ-1:0] irq_i,
   output logic             pwr_down_ok_o,
   output logic             restore_req_o,
   output logic             core_ready_o,
   output logic [N_IRQ-1:0] wake_src_o
);
   localparam int CW = $clog2(DLY_DEEP + 1);
   localparam logic [CW-1:0] LOAD_SLEEP = CW'(DLY_SLEEP - 1);
   localparam logic [CW-1:0] LOAD_DEEP  = CW'(DLY_DEEP - 1);

   initial begin : param_chk
      assert (N_IRQ >= 1)           else $error("N_IRQ must be positive");
      assert (DLY_SLEEP >= 1)       else $error("DLY_SLEEP must be at least 1");
      assert (DLY_DEEP > DLY_SLEEP) else $error("DLY_DEEP must exceed DLY_SLEEP");
   end

   wake_state_e      state_q, state_d;
   logic [N_IRQ-1:0] irq_s;
   logic [N_IRQ-1:0] pend_q;
   logic             deep_lvl_q;
   logic             cnt_load, cnt_done;
   logic             any_irq;

   wake_irq_sync #(.N(N_IRQ), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .irq_i (irq_i),
      .irq_o (irq_s)
   );

   assign any_irq = |irq_s;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         WS_IDLE:    if (deep_sleep_i && !dbg_attached_i) state_d = WS_ARMED;
         WS_ARMED: begin
            if (!deep_sleep_i || dbg_attached_i) state_d = WS_IDLE;
            else if (core_sleeping_i)            state_d = WS_PDOWN;
         end
         WS_PDOWN:   if (any_irq || dbg_attached_i) state_d = WS_RESTORE;
         WS_RESTORE: if (cnt_done)                  state_d = WS_READY;
         WS_READY:   if (!core_sleeping_i)          state_d = WS_IDLE;
         default:    state_d = WS_IDLE;
      endcase
   end

   assign cnt_load = (state_q == WS_PDOWN) && (state_d == WS_RESTORE);

   wake_delay_cnt #(.CW(CW)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (cnt_load),
      .load_val_i (deep_lvl_q ? LOAD_DEEP : LOAD_SLEEP),
      .dec_i      (state_q == WS_RESTORE),
      .done_o     (cnt_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= WS_IDLE;
         pend_q     <= '0;
         deep_lvl_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == WS_ARMED && state_d == WS_PDOWN) deep_lvl_q <= pd_level_i;
         if (state_q == WS_IDLE || state_q == WS_ARMED) pend_q <= '0;
         else                                          pend_q <= pend_q | irq_s;
      end
   end

   assign pwr_down_ok_o = (state_q == WS_PDOWN);
   assign restore_req_o = (state_q == WS_RESTORE);
   assign core_ready_o  = (state_q == WS_READY);
   assign wake_src_o    = core_ready_o ? pend_q : '0;

   // R2
   pd_grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_down_ok_o) |-> $past(deep_sleep_i && core_sleeping_i && !dbg_attached_i));
   // R4
   dbg_blocks_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_attached_i |=> !pwr_down_ok_o);
   // R7
   ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_ready_o && core_sleeping_i) |=> core_ready_o);
   // R8
   src_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_ready_o && $past(core_ready_o)) |-> ((wake_src_o & $past(wake_src_o)) == $past(wake_src_o)));
   // R9
   idle_no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_down_ok_o && !restore_req_o) |=> !restore_req_o);
endmodule

// File: tb/tb_wake_seq_ctrl.sv
`timescale 1ns/1ps
module tb_wake_seq_ctrl;
   localparam int N  = 8;
   localparam int SS = 2;
   localparam int DS = 4;
   localparam int DD = 12;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         deep_sleep = 1'b0, core_sleeping = 1'b0, dbg = 1'b0, pd_level = 1'b0;
   logic [N-1:0] irq = '0;
   logic         pwr_ok, rst_req, ready;
   logic [N-1:0] src;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   wake_seq_ctrl #(.N_IRQ(N), .SYNC_STAGES(SS), .DLY_SLEEP(DS), .DLY_DEEP(DD)) dut (
      .clk(clk), .rst_n(rst_n), .deep_sleep_i(deep_sleep), .core_sleeping_i(core_sleeping),
      .dbg_attached_i(dbg), .pd_level_i(pd_level), .irq_i(irq),
      .pwr_down_ok_o(pwr_ok), .restore_req_o(rst_req), .core_ready_o(ready), .wake_src_o(src)
   );

   // behavioural reference: 0 idle, 1 armed, 2 powered down, 3 restoring, 4 ready
   int           m_st = 0, m_cnt = 0;
   bit           m_lvl = 0;
   logic [N-1:0] m_pend = '0, m_s1 = '0, m_s2 = '0;

   always @(posedge clk) begin
      int ns;
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_lvl = 0; m_pend = '0; m_s1 = '0; m_s2 = '0;
      end else begin
         ns = m_st;
         case (m_st)
            0: if (deep_sleep && !dbg) ns = 1;
            1: if (!deep_sleep || dbg) ns = 0; else if (core_sleeping) ns = 2;
            2: if (m_s2 != 0 || dbg) ns = 3;
            3: if (m_cnt == 0) ns = 4;
            4: if (!core_sleeping) ns = 0;
            default: ns = 0;
         endcase
         if (m_st == 1 && ns == 2) m_lvl = pd_level;
         if (m_st == 2 && ns == 3) m_cnt = (m_lvl ? DD : DS) - 1;
         else if (m_st == 3 && m_cnt > 0) m_cnt--;
         if (m_st <= 1) m_pend = '0; else m_pend = m_pend | m_s2;
         m_st = ns;
         m_s2 = m_s1;
         m_s1 = irq;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         if (!rst_n) begin
            chk("R1 pwr_down_ok", 32'(pwr_ok), 0);
            chk("R1 restore_req", 32'(rst_req), 0);
            chk("R1 core_ready", 32'(ready), 0);
            chk("R1 wake_src", 32'(src), 0);
         end else begin
            chk("R2,R3,R4 pwr_down_ok", 32'(pwr_ok), 32'(m_st == 2));
            chk("R5,R6,R9 restore_req", 32'(rst_req), 32'(m_st == 3));
            chk("R7 core_ready", 32'(ready), 32'(m_st == 4));
            chk("R8 wake_src", 32'(src), 32'((m_st == 4) ? m_pend : '0));
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog all requirements actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic quiet();
      deep_sleep = 0; core_sleeping = 0; dbg = 0; pd_level = 0; irq = '0;
      cyc(6);
   endtask

   task automatic go_down(input bit lvl);
      deep_sleep = 1; pd_level = lvl;
      cyc(2);
      core_sleeping = 1;
      cyc(2);
      chk("R2 powered down", 32'(pwr_ok), 1);
   endtask

   // wake with a first line, optionally a second line during restore; count window
   task automatic wake_and_measure(input logic [N-1:0] first, input logic [N-1:0] late,
                                   input int exp_len, input string req);
      int len = 0;
      for (int i = 0; i < 40; i++) begin
         if (i == 0) irq = first;
         else if (i == 1) irq = '0;
         else if (i == 4) irq = late;
         else if (i == 5) irq = '0;
         cyc(1);
         if (rst_req) len++;
      end
      chk(req, 32'(len), 32'(exp_len));
   endtask

   initial begin
      cyc(3);
      chk("R1 reset pwr_down_ok", 32'(pwr_ok), 0);
      chk("R1 reset ready", 32'(ready), 0);
      rst_n = 1;
      cyc(1);
      chk("R1 after reset restore_req", 32'(rst_req), 0);
      chk("R1 after reset wake_src", 32'(src), 0);
      cyc(2);

      // R5, R8: shallow level, second line arrives during restore
      go_down(0);
      wake_and_measure(8'h04, 8'h20, DS, "R5 restore window shallow");
      chk("R7 ready after restore", 32'(ready), 1);
      chk("R8 late line kept", 32'(src), 32'h24);
      cyc(5);
      chk("R7 ready held while sleeping", 32'(ready), 1);
      core_sleeping = 0;
      cyc(1);
      chk("R7 ready drops", 32'(ready), 0);
      chk("R8 src cleared", 32'(src), 0);
      quiet();

      // R6: deeper level
      go_down(1);
      wake_and_measure(8'h81, 8'h00, DD, "R6 restore window deep");
      chk("R8 src deep", 32'(src), 32'h81);
      quiet();

      // R3: abort by clearing deep sleep while armed
      deep_sleep = 1; cyc(2);
      deep_sleep = 0; cyc(1);
      core_sleeping = 1;
      for (int i = 0; i < 5; i++) begin
         cyc(1);
         chk("R3 no grant after deep-sleep clear", 32'(pwr_ok), 0);
      end
      quiet();

      // R3: abort by debugger while armed
      deep_sleep = 1; cyc(2);
      dbg = 1; cyc(1);
      core_sleeping = 1;
      for (int i = 0; i < 5; i++) begin
         cyc(1);
         chk("R3 no grant with debugger", 32'(pwr_ok), 0);
      end
      quiet();

      // R4: debugger attached while powered down
      go_down(0);
      dbg = 1;
      cyc(1);
      chk("R4 grant withdrawn", 32'(pwr_ok), 0);
      chk("R4 restore started", 32'(rst_req), 1);
      cyc(DS);
      chk("R4 ready after debugger wake", 32'(ready), 1);
      chk("R8 no source on debugger wake", 32'(src), 0);
      quiet();

      // R9: interrupts while idle and while armed
      irq = 8'hFF;
      for (int i = 0; i < 4; i++) begin
         cyc(1);
         chk("R9 idle irq ignored", 32'(rst_req), 0);
      end
      deep_sleep = 1;
      for (int i = 0; i < 4; i++) begin
         cyc(1);
         chk("R9 armed irq ignored", 32'(rst_req), 0);
      end
      irq = '0;
      cyc(4);
      core_sleeping = 1;
      cyc(4);
      chk("R9 no stale wake", 32'(pwr_ok), 1);
      quiet();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule